// File: doc/BRIEF.md
# Bipolar Line Decoder with Coding-Error Detector

The block sits behind a line receiver's slicer and works on the two logic rails that mark positive and negative pulses. Each clock it samples one line symbol: a positive mark, a negative mark or a zero. It removes the zero-substitution patterns of either the three-zero code (B3ZS, used for DS3 and STS-1) or the four-zero code (HDB3, used for E3). The result is a single-rail NRZ bit stream on `data_o`.

Alongside every decoded bit, `lcv_o` pulses for one clock when the symbol that completes a coding fault passes through. A fault is any of the following: too many zeros in a row, a substitution mark placed too close to the preceding mark, an even count of ordinary marks between two substitution marks, or marks on both rails at once. With the decoder switched off, the two rails are passed through as dual-rail data. Both paths have the same fixed four-clock latency.

A polarity input chooses which clock edge samples the rails and runs the pipeline.

Top module: `bpv_decoder`

## Requirements
- R1: During reset, and for the first four active edges after reset is released, `data_o` and `lcv_o` are 0.
- R2: A symbol sampled on an active edge reaches the outputs on the fourth active edge after that one, in every mode.
- R3: With `clk_inv_i`=0 the active edge is the rising edge of `clk_i`; with `clk_inv_i`=1 it is the falling edge.
- R4: Symbol encoding is as follows. `pos_i`=1 with `neg_i`=0 is a positive mark, `neg_i`=1 with `pos_i`=0 is a negative mark, and both at 0 is a zero. A violation mark (V) is a single-rail mark whose polarity equals that of the last earlier single-rail mark; the first mark after reset is never a V. With decoding on, `data_o` is 1 for a mark and 0 for a zero, except as R5 changes it.
- R5: A V that is not flagged by R7 or R8 is decoded as 0. In B3ZS mode (`hdb3_i`=0), a mark two symbols before that V is also decoded as 0. In HDB3 mode (`hdb3_i`=1), a mark three symbols before that V is also decoded as 0. A correctly coded stream therefore decodes to its original data with `lcv_o` at 0.
- R6: `lcv_o` pulses once per zero run, on the zero that makes the run reach 3 (B3ZS) or 4 (HDB3) zeros. Later zeros of the same run give no further pulse.
- R7: In B3ZS mode, a V that directly follows a mark pulses `lcv_o` and is decoded as 1.
- R8: In HDB3 mode, a V with a mark one or two symbols before it pulses `lcv_o` and is decoded as 1.
- R9: At a V, if an earlier V exists since reset and the count of ordinary single-rail (non-V) marks since that V is even, `lcv_o` pulses at this V.
- R10: Marks on both rails in one symbol decode as 1 and pulse `lcv_o`. Such a symbol neither changes the polarity history nor counts for R9, and it ends a zero run.
- R11: With `bypass_i`=1, `data_o` carries `pos_i` and `lcv_o` carries `neg_i`, each delayed per R2, and no fault indication is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_inv_i | input | 1 | 1 selects the falling edge as the active edge |
| hdb3_i | input | 1 | 0 selects the three-zero code, 1 the four-zero code |
| bypass_i | input | 1 | 1 disables decoding and passes both rails through |
| pos_i | input | 1 | Positive-mark rail |
| neg_i | input | 1 | Negative-mark rail |
| data_o | output | 1 | Decoded NRZ bit, or the delayed positive rail in bypass |
| lcv_o | output | 1 | Coding-fault pulse, or the delayed negative rail in bypass |

## Verification
The hardest case to reach from the ports is a four-zero substitution whose leading mark has already reached the last pipeline stage when the V arrives. That mark has to be suppressed as it leaves the block, while spacing, parity and zero-run state are updated at the same moment. The bench reaches this case, and every other mark/zero/double-mark ordering over five symbols, by concatenating all 1024 words of four symbol values into one stream and replaying it in both codes, both clock edges and both decoder settings. Long pseudo-random data passed through an encoder model in the bench then confirms that legal streams decode back to the source bits without a fault pulse.

// File: rtl/bpv_pkg.sv
package bpv_pkg;

  // one line symbol as it moves through the window
  typedef struct packed {
    logic vld;  // holds a sampled symbol
    logic pos;  // raw positive rail
    logic neg;  // raw negative rail
    logic mrk;  // raw mark, never cleared
    logic dat;  // decoded bit, cleared by substitution removal
    logic lcv;  // fault flag attached at entry
  } sym_t;

endpackage

// File: rtl/bpv_window.sv
module bpv_window
  import bpv_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int MID   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pos_i,
  input  logic             neg_i,
  input  logic             viol_i,
  input  logic             clr_v_i,
  input  logic             clr_mid_i,
  output logic             cur_vld_o,
  output logic             cur_pos_o,
  output logic             cur_neg_o,
  output logic [DEPTH-1:1] marks_o,
  output logic             tail_vld_o,
  output logic             tail_pos_o,
  output logic             tail_neg_o,
  output logic             tail_dat_o,
  output logic             tail_lcv_o
);

  sym_t st_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q[0] <= '0;
    else         st_q[0] <= '{vld: 1'b1, pos: pos_i, neg: neg_i,
                              mrk: pos_i | neg_i, dat: pos_i | neg_i, lcv: 1'b0};
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    sym_t nxt;
    always_comb begin
      nxt = st_q[i-1];
      if (i == 1) begin
        nxt.dat = nxt.dat & ~clr_v_i;
        nxt.lcv = nxt.lcv | viol_i;
      end
      // leading mark of a short substitution enters this stage
      if (i == MID + 1) nxt.dat = nxt.dat & ~clr_mid_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[i] <= '0;
      else         st_q[i] <= nxt;
    end
    assign marks_o[i] = st_q[i].mrk;
  end

  assign cur_vld_o  = st_q[0].vld;
  assign cur_pos_o  = st_q[0].pos;
  assign cur_neg_o  = st_q[0].neg;
  assign tail_vld_o = st_q[DEPTH-1].vld;
  assign tail_pos_o = st_q[DEPTH-1].pos;
  assign tail_neg_o = st_q[DEPTH-1].neg;
  assign tail_dat_o = st_q[DEPTH-1].dat;
  assign tail_lcv_o = st_q[DEPTH-1].lcv;

  // unused raw fields of stage 0 are consumed by stage 1 above
  logic unused_s0;
  assign unused_s0 = st_q[0].mrk ^ st_q[0].dat ^ st_q[0].lcv;

endmodule

// File: rtl/bpv_rules.sv
module bpv_rules #(
  parameter int B3_RUN = 2,
  parameter int HD_RUN = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hdb3_i,
  input  logic              vld_i,
  input  logic              pos_i,
  input  logic              neg_i,
  input  logic [HD_RUN:1]   marks_i,
  output logic              viol_o,
  output logic              clr_v_o,
  output logic              clr_mid_o,
  output logic              clr_end_o
);

  localparam int ZW = $clog2(HD_RUN + 2);
  localparam logic [ZW-1:0] ZMAX = '1;

  logic          have_q, ppol_q, bpar_q, seen_q;
  logic [ZW-1:0] zrun_q;

  logic mark, dbl, single, is_v, is_b;
  logic zero_bad, gap_bad, par_bad, sub_ok;
  int   lim;

  assign mark   = pos_i | neg_i;
  assign dbl    = pos_i & neg_i;
  assign single = vld_i & mark & ~dbl;
  assign is_v   = single & have_q & (pos_i == ppol_q);
  assign is_b   = single & ~is_v;
  assign lim    = hdb3_i ? HD_RUN : B3_RUN;

  always_comb begin
    gap_bad = 1'b0;
    for (int j = 1; j <= HD_RUN; j++)
      if (j < lim) gap_bad = gap_bad | (is_v & marks_i[j]);
  end

  assign zero_bad  = vld_i & ~mark & (zrun_q == ZW'(lim));
  assign par_bad   = is_v & seen_q & ~bpar_q;
  assign sub_ok    = is_v & ~gap_bad;
  assign viol_o    = zero_bad | gap_bad | par_bad | (vld_i & dbl);
  assign clr_v_o   = sub_ok;
  assign clr_mid_o = sub_ok & ~hdb3_i & marks_i[B3_RUN];
  assign clr_end_o = sub_ok & hdb3_i & marks_i[HD_RUN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      ppol_q <= 1'b0;
      bpar_q <= 1'b0;
      seen_q <= 1'b0;
      zrun_q <= '0;
    end else begin
      if (single) begin
        have_q <= 1'b1;
        ppol_q <= pos_i;
      end
      if (is_v)      bpar_q <= 1'b0;
      else if (is_b) bpar_q <= ~bpar_q;
      if (is_v) seen_q <= 1'b1;
      if (vld_i) begin
        if (mark)             zrun_q <= '0;
        else if (zrun_q != ZMAX) zrun_q <= zrun_q + 1'b1;
      end
    end
  end

  // one pulse per zero run
  p_zero_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_bad |=> !zero_bad);

  // a V cannot follow a reset without an earlier mark
  p_v_after_mark_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(seen_q) |-> have_q);

endmodule

// File: rtl/bpv_decoder.sv
module bpv_decoder
  import bpv_pkg::*;
#(
  parameter int B3_RUN = 2,
  parameter int HD_RUN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_inv_i,
  input  logic hdb3_i,
  input  logic bypass_i,
  input  logic pos_i,
  input  logic neg_i,
  output logic data_o,
  output logic lcv_o
);

  localparam int DEPTH = HD_RUN + 1;
  localparam int WARM  = DEPTH + 1;
  localparam int WW    = $clog2(WARM + 1);

  logic clk_s;
  assign clk_s = clk_i ^ clk_inv_i;

  logic             cur_vld, cur_pos, cur_neg;
  logic [DEPTH-1:1] marks;
  logic             tail_vld, tail_pos, tail_neg, tail_dat, tail_lcv;
  logic             viol, clr_v, clr_mid, clr_end;

  bpv_window #(.DEPTH(DEPTH), .MID(B3_RUN)) u_win (
    .clk_i      (clk_s),
    .rst_ni     (rst_ni),
    .pos_i      (pos_i),
    .neg_i      (neg_i),
    .viol_i     (viol),
    .clr_v_i    (clr_v),
    .clr_mid_i  (clr_mid),
    .cur_vld_o  (cur_vld),
    .cur_pos_o  (cur_pos),
    .cur_neg_o  (cur_neg),
    .marks_o    (marks),
    .tail_vld_o (tail_vld),
    .tail_pos_o (tail_pos),
    .tail_neg_o (tail_neg),
    .tail_dat_o (tail_dat),
    .tail_lcv_o (tail_lcv)
  );

  bpv_rules #(.B3_RUN(B3_RUN), .HD_RUN(HD_RUN)) u_rules (
    .clk_i     (clk_s),
    .rst_ni    (rst_ni),
    .hdb3_i    (hdb3_i),
    .vld_i     (cur_vld),
    .pos_i     (cur_pos),
    .neg_i     (cur_neg),
    .marks_i   (marks),
    .viol_o    (viol),
    .clr_v_o   (clr_v),
    .clr_mid_o (clr_mid),
    .clr_end_o (clr_end)
  );

  always_ff @(posedge clk_s or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= 1'b0;
      lcv_o  <= 1'b0;
    end else begin
      data_o <= tail_vld & (bypass_i ? tail_pos : (tail_dat & ~clr_end));
      lcv_o  <= tail_vld & (bypass_i ? tail_neg : tail_lcv);
    end
  end

  // edges since reset, for history-bounded checks
  logic [WW-1:0] warm_q;
  always_ff @(posedge clk_s or negedge rst_ni) begin
    if (!rst_ni)                warm_q <= '0;
    else if (warm_q != WW'(WARM)) warm_q <= warm_q + 1'b1;
  end

  p_idle_r1: assert property (@(posedge clk_s) disable iff (!rst_ni)
    (warm_q < WW'(WARM)) |-> (!data_o && !lcv_o));

  // depth 5 matches WARM at the default HD_RUN
  p_pass_dat_r11: assert property (@(posedge clk_s) disable iff (!rst_ni)
    (warm_q == WW'(WARM)) && $past(bypass_i) |-> data_o == $past(pos_i, 5));

  p_pass_lcv_r11: assert property (@(posedge clk_s) disable iff (!rst_ni)
    (warm_q == WW'(WARM)) && $past(bypass_i) |-> lcv_o == $past(neg_i, 5));

  p_one_needs_mark_r4: assert property (@(posedge clk_s) disable iff (!rst_ni)
    (warm_q == WW'(WARM)) && !$past(bypass_i) && data_o |-> $past(pos_i | neg_i, 5));

endmodule

// File: tb/bpv_decoder_test.sv
`timescale 1ns/1ps
module bpv_decoder_test;

  localparam int MAXN = 5200;

  logic clk = 1'b0, rst_n = 1'b0, inv = 1'b0, hd = 1'b0, byp = 1'b0;
  logic pos = 1'b0, neg = 1'b0;
  logic data, lcv;

  always #2.5 clk = ~clk;

  bpv_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .clk_inv_i(inv), .hdb3_i(hd),
    .bypass_i(byp), .pos_i(pos), .neg_i(neg), .data_o(data), .lcv_o(lcv)
  );

  int checks = 0, errors = 0;
  bit sp [MAXN], sn [MAXN], ed [MAXN], el [MAXN], nz [MAXN];
  string dtag [MAXN], ltag [MAXN];
  int unsigned seed = 32'h1234_5678;

  task automatic edge_wait();
    if (inv) @(negedge clk); else @(posedge clk);
    #1;
  endtask

  task automatic chk(logic act, logic exp, string tag, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic start_run(bit h, bit i, bit b);
    rst_n = 1'b0; pos = 1'b0; neg = 1'b0;
    hd = h; inv = i; byp = b;
    #15;
    chk(data, 1'b0, "R1", "data_o in reset");
    chk(lcv,  1'b0, "R1", "lcv_o in reset");
    edge_wait();
    rst_n = 1'b1;
  endtask

  // reference rules applied over a whole stream
  task automatic build_model(int n, bit h);
    int lim, run, lastv, bsince;
    bit have, ppol;
    lim = h ? 3 : 2; run = 0; lastv = -1; bsince = 0; have = 0; ppol = 0;
    for (int k = 0; k < n; k++) begin
      bit mk, db, isv, bad;
      mk = sp[k] | sn[k];
      db = sp[k] & sn[k];
      ed[k] = mk; el[k] = 0; dtag[k] = "R4"; ltag[k] = "R4";
      if (!mk) begin
        run++;
        if (run == lim + 1) begin el[k] = 1; ltag[k] = "R6"; end
      end else run = 0;
      if (db) begin
        el[k] = 1; ltag[k] = "R10"; dtag[k] = "R10";
      end else if (mk) begin
        isv = have && (sp[k] == ppol);
        have = 1; ppol = sp[k];
        if (isv) begin
          bad = (k >= 1 && (sp[k-1] | sn[k-1])) ||
                (h && k >= 2 && (sp[k-2] | sn[k-2]));
          if (bad) begin
            el[k] = 1; ltag[k] = h ? "R8" : "R7"; dtag[k] = h ? "R8" : "R7";
          end else begin
            ed[k] = 0; dtag[k] = "R5";
            if (!h && k >= 2 && (sp[k-2] | sn[k-2])) begin ed[k-2] = 0; dtag[k-2] = "R5"; end
            if (h && k >= 3 && (sp[k-3] | sn[k-3])) begin ed[k-3] = 0; dtag[k-3] = "R5"; end
          end
          if (lastv >= 0 && (bsince % 2) == 0) begin el[k] = 1; ltag[k] = "R9"; end
          lastv = k; bsince = 0;
        end else bsince++;
      end
    end
  endtask

  task automatic emit(int k, bit p);
    sp[k] = p; sn[k] = ~p;
  endtask

  // legal encoder for end-to-end decode of R5
  task automatic encode(int n, bit h);
    int lim, i, bc;
    bit lp, allz;
    lim = h ? 3 : 2; i = 0; bc = 0; lp = 0;
    for (int k = 0; k < n + 4; k++) begin sp[k] = 0; sn[k] = 0; end
    while (i < n) begin
      allz = (i + lim < n);
      for (int d = 0; d <= lim; d++) if (i + d < n && nz[i+d]) allz = 0;
      if (nz[i]) begin
        lp = ~lp; emit(i, lp); bc++; i++;
      end else if (allz) begin
        if (bc % 2 == 1) emit(i + lim, lp);
        else begin lp = ~lp; emit(i, lp); emit(i + lim, lp); end
        bc = 0; i += lim + 1;
      end else i++;
    end
  endtask

  task automatic play(int n, bit e2e);
    for (int k = 0; k < n + 4; k++) begin
      int j;
      string pre;
      pos = sp[k]; neg = sn[k];
      edge_wait();
      j = k - 4;
      pre = inv ? "R3 " : "";
      if (j < 0) begin
        chk(data, 1'b0, {pre, "R1"}, "data_o before first symbol");
        chk(lcv,  1'b0, {pre, "R1"}, "lcv_o before first symbol");
      end else if (j < n) begin
        if (byp) begin
          chk(data, sp[j], {pre, "R11"}, "data_o passthrough");
          chk(lcv,  sn[j], {pre, "R11"}, "lcv_o passthrough");
        end else if (e2e) begin
          chk(data, nz[j], {pre, "R5"}, "decoded data");
          chk(lcv,  1'b0,  {pre, "R5"}, "fault on legal stream");
        end else begin
          chk(data, ed[j], {pre, dtag[j]}, "decoded data");
          chk(lcv,  el[j], {pre, ltag[j]}, "fault pulse");
        end
      end
    end
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R2: single mark lands on the fourth edge after capture
    start_run(1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 6; k++) begin
      pos = (k == 0); neg = 1'b0;
      edge_wait();
      chk(data, (k == 4), "R2", "latency of first mark");
    end

    // all five-symbol words of {zero, +, -, both}
    for (int w = 0; w < 1024; w++)
      for (int d = 0; d < 5; d++) begin
        int v;
        v = (w >> (2 * d)) & 3;
        sp[w*5+d] = (v == 1) || (v == 3);
        sn[w*5+d] = (v == 2) || (v == 3);
      end
    for (int k = 5120; k < 5124; k++) begin sp[k] = 0; sn[k] = 0; end

    for (int m = 0; m < 8; m++) begin
      bit h, i, b;
      h = m[0]; i = m[1]; b = m[2];
      build_model(5124, h);
      start_run(h, i, b);
      play(5120, 1'b0);
    end

    for (int r = 0; r < 2; r++) begin
      for (int k = 0; k < 3000; k++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        nz[k] = ((seed >> 16) & 3) == 0;
      end
      encode(3000, r[0]);
      start_run(r[0], r[0], 1'b0);
      play(3000, 1'b1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule